// File: doc/BRIEF.md
# Processor Interrupt Acceptance Latch

This block sits in front of a single processor core and decides whether a priority level raised by the interrupt controller becomes a hard interrupt request. It has fifteen usable level request lines, one for each priority from 1 to 15. The line at position 0 stands for "no level" and is ignored. The block keeps one pending trap code. When the latch is free, a rising level is accepted and stored as an external-interrupt trap code. When an external interrupt is already pending, a later level replaces it only if that level is strictly higher. Any other pending exception blocks new levels. Every rising level also pulses a wake signal, so that a halted core resumes whether or not the level was taken.

The latch is a three-state machine. The states are FREE (nothing pending), EXTERNAL (an external interrupt of a stored level is pending) and EXCEPTION (a non-interrupt exception code is pending). The transitions are:
- ACCEPT: FREE to EXTERNAL on a rising level.
- UPGRADE: EXTERNAL to EXTERNAL on a strictly higher rising level.
- LOAD: any state to EXCEPTION when a nonzero exception code is loaded.
- DROP: any state to FREE when the core acknowledges the trap, or when a zero code is loaded.

An acknowledge is applied first. Levels that rise in the same cycle are then judged against the freed latch.

Top module: `irq_accept_latch`

## Requirements
- R1: After reset, hard_irq is 0, wake is 0 and trap_code is 0x00.
- R2: A rising edge on any level line 1 to 15 makes wake 1 in the next cycle, whether or not the level is accepted. A cycle with no such edge gives wake 0 in the next cycle.
- R3: When the latch is free, a rising level L gives trap_code = 0x10 | L in the next cycle: the upper nibble is the external-interrupt type 1 and bits 3:0 hold the level. hard_irq is 1 in the same cycle.
- R4: While an external interrupt of level P is pending, a rising level L > P replaces it. trap_code becomes 0x10 | L and hard_irq stays 1.
- R5: While an external interrupt of level P is pending, a rising level L <= P leaves trap_code and hard_irq unchanged.
- R6: When several levels rise in the same cycle, only the highest of them is considered for acceptance.
- R7: A falling level line, or a line held steady, leaves trap_code and hard_irq unchanged.
- R8: trap_ack clears trap_code to 0x00 and hard_irq to 0 in the next cycle. A level that rises in the same cycle as trap_ack is judged against the cleared latch and is accepted.
- R9: exc_load stores exc_code as the trap code and forces hard_irq to 0. It takes precedence over trap_ack and over rising levels in the same cycle. A loaded code of 0x00 leaves the latch free.
- R10: While a non-interrupt exception is pending, rising levels leave trap_code and hard_irq unchanged but still produce wake.
- R11: Level line 0 has no effect: its edges produce neither wake nor acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_in | input | 16 | Level request lines; bit k is priority k; bit 0 is ignored |
| trap_ack | input | 1 | Core has taken the pending trap; clears the latch |
| exc_load | input | 1 | Load exc_code as a pending non-interrupt exception |
| exc_code | input | 8 | Exception trap code to load |
| hard_irq | output | 1 | Hard interrupt request to the core |
| wake | output | 1 | One-cycle pulse that releases a halted core |
| trap_code | output | 8 | Pending trap code; 0x00 when the latch is free |

## Verification
Every result (hard_irq, trap_code and wake) is registered. Each is therefore due exactly one rising edge after the stimulus that causes it, including the edge detection on lvl_in. The bench drives each stimulus on a falling edge and pushes the expected triple into a queue at the same moment. A monitor pops that triple and compares it 1 ns after the following rising edge, so every comparison lands in the one cycle where the result first appears and before the next stimulus is applied.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Occupancy of the pending-trap latch
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_EXT  = 2'd1,
        ST_EXC  = 2'd2
    } latch_state_t;

endpackage

// File: rtl/irq_level_edge.sv
module irq_level_edge #(
    parameter int NLVL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] lvl,
    output logic [NLVL-1:0] rise
);

    // Position 0 means "no level" and never produces an edge
    localparam logic [NLVL-1:0] LIVE_MASK = {{(NLVL-1){1'b1}}, 1'b0};

    logic [NLVL-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q & LIVE_MASK;

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int NLVL = 16,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] req,
    output logic            found,
    output logic [LW-1:0]   level
);

    // Scan upward so that the highest set position wins
    always_comb begin
        found = 1'b0;
        level = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (req[i]) begin
                found = 1'b1;
                level = i[LW-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_accept_latch.sv
module irq_accept_latch
    import irq_latch_pkg::*;
#(
    parameter int NLVL     = 16,
    parameter int CW       = 8,
    parameter int EXT_TYPE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] lvl_in,
    input  logic            trap_ack,
    input  logic            exc_load,
    input  logic [CW-1:0]   exc_code,
    output logic            hard_irq,
    output logic            wake,
    output logic [CW-1:0]   trap_code
);

    localparam int LW = $clog2(NLVL);
    localparam int TW = CW - LW;
    localparam logic [TW-1:0] EXT_TAG = EXT_TYPE[TW-1:0];

    logic [NLVL-1:0] rise;
    logic            pick_found;
    logic [LW-1:0]   pick_lvl;

    latch_state_t    state_q, state_d, base_st;
    logic [LW-1:0]   lvl_q, lvl_d;
    logic [CW-1:0]   exc_q, exc_d;
    logic            wake_q;

    irq_level_edge #(.NLVL(NLVL)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl_in),
        .rise (rise)
    );

    irq_level_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
        .req  (rise),
        .found(pick_found),
        .level(pick_lvl)
    );

    // Next-state decision: acknowledge frees first, exception load wins
    always_comb begin
        base_st = trap_ack ? ST_FREE : state_q;
        state_d = base_st;
        lvl_d   = lvl_q;
        exc_d   = exc_q;
        if (exc_load) begin
            exc_d   = exc_code;
            state_d = (exc_code != '0) ? ST_EXC : ST_FREE;
        end else begin
            unique case (base_st)
                ST_FREE: begin
                    if (pick_found) begin
                        state_d = ST_EXT;
                        lvl_d   = pick_lvl;
                    end
                end
                ST_EXT: begin
                    if (pick_found && (pick_lvl > lvl_q)) begin
                        lvl_d = pick_lvl;
                    end
                end
                ST_EXC: begin
                    state_d = ST_EXC;
                end
                default: begin
                    state_d = ST_FREE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            lvl_q   <= '0;
            exc_q   <= '0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            exc_q   <= exc_d;
            wake_q  <= |rise;
        end
    end

    // Outputs decoded from the held state
    always_comb begin
        wake = wake_q;
        unique case (state_q)
            ST_FREE: begin
                hard_irq  = 1'b0;
                trap_code = '0;
            end
            ST_EXT: begin
                hard_irq  = 1'b1;
                trap_code = {EXT_TAG, lvl_q};
            end
            ST_EXC: begin
                hard_irq  = 1'b0;
                trap_code = exc_q;
            end
            default: begin
                hard_irq  = 1'b0;
                trap_code = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_accept_latch_chk.sv
module irq_accept_latch_chk #(
    parameter int NLVL     = 16,
    parameter int CW       = 8,
    parameter int EXT_TYPE = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NLVL-1:0] lvl_in,
    input logic            trap_ack,
    input logic            exc_load,
    input logic [CW-1:0]   exc_code,
    input logic            hard_irq,
    input logic            wake,
    input logic [CW-1:0]   trap_code
);

    localparam int LW = $clog2(NLVL);
    localparam int TW = CW - LW;
    localparam logic [TW-1:0] EXT_TAG = EXT_TYPE[TW-1:0];

    logic [NLVL-1:0] seen_q;
    logic [NLVL-1:0] up_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= lvl_in;
    end

    assign up_c = lvl_in & ~seen_q & {{(NLVL-1){1'b1}}, 1'b0};

    AST_WAKE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_c != '0) |=> wake); // R2
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_c == '0) |=> !wake); // R11
    AST_FREE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_irq && trap_code == '0 && !exc_load && up_c != '0)
        |=> (hard_irq && trap_code[CW-1:LW] == EXT_TAG)); // R3
    AST_LEVEL_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_irq && !trap_ack && !exc_load)
        |=> (hard_irq && trap_code[LW-1:0] >= $past(trap_code[LW-1:0]))); // R4
    AST_STEADY_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_ack && !exc_load && up_c == '0)
        |=> ($stable(trap_code) && $stable(hard_irq))); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ack && !exc_load && up_c == '0)
        |=> (trap_code == '0 && !hard_irq)); // R8
    AST_EXC_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_load |=> (!hard_irq && trap_code == $past(exc_code))); // R9
    AST_EXC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_irq && trap_code != '0 && !trap_ack && !exc_load)
        |=> (!hard_irq && $stable(trap_code))); // R10

endmodule

bind irq_accept_latch irq_accept_latch_chk #(
    .NLVL(NLVL), .CW(CW), .EXT_TYPE(EXT_TYPE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   (lvl_in),
    .trap_ack (trap_ack),
    .exc_load (exc_load),
    .exc_code (exc_code),
    .hard_irq (hard_irq),
    .wake     (wake),
    .trap_code(trap_code)
);

// File: tb/irq_accept_latch_test.sv
module irq_accept_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lvl_in = '0;
    logic        trap_ack = 1'b0;
    logic        exc_load = 1'b0;
    logic [7:0]  exc_code = '0;
    logic        hard_irq;
    logic        wake;
    logic [7:0]  trap_code;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    irq_accept_latch uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (lvl_in),
        .trap_ack (trap_ack),
        .exc_load (exc_load),
        .exc_code (exc_code),
        .hard_irq (hard_irq),
        .wake     (wake),
        .trap_code(trap_code)
    );

    // Driver: apply one cycle of stimulus and queue its expected result
    task automatic step(input logic [15:0] lv, input logic ack, input logic el,
                        input logic [7:0] ec, input logic eh, input logic ew,
                        input logic [7:0] ecode, input string tag);
        @(negedge clk);
        lvl_in   = lv;
        trap_ack = ack;
        exc_load = el;
        exc_code = ec;
        exp_q.push_back({eh, ew, ecode});
        tag_q.push_back(tag);
    endtask

    // Monitor: results are due one rising edge after the stimulus
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({hard_irq, wake, trap_code} !== e) begin
                errors++;
                $display("FAIL %s: hard=%0b wake=%0b code=%02h expected hard=%0b wake=%0b code=%02h",
                         t, hard_irq, wake, trap_code, e[9], e[8], e[7:0]);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    lvl_in            ack   el    ec     hard  wake  code
        step(16'h0000,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R1");
        step(16'h0020,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h15, "R3");
        step(16'h0020,          1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h15, "R7");
        step(16'h0028,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h15, "R5");
        step(16'h0228,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h19, "R4");
        step(16'h1008,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h1C, "R4");
        step(16'h0008,          1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h1C, "R7");
        step(16'h1008,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h1C, "R5");
        step(16'h1008,          1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
        step(16'h0000,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R7");
        step(16'h4084,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h1E, "R6");
        step(16'h4085,          1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h1E, "R11");
        step(16'h4095,          1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h14, "R8");
        step(16'h4095,          1'b0, 1'b1, 8'h2B, 1'b0, 1'b0, 8'h2B, "R9");
        step(16'hC095,          1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h2B, "R10");
        step(16'hC095,          1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
        step(16'h0000,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R7");
        step(16'h0001,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R11");
        step(16'h0040,          1'b0, 1'b1, 8'h07, 1'b0, 1'b1, 8'h07, "R9");
        step(16'h0040,          1'b1, 1'b1, 8'h09, 1'b0, 1'b0, 8'h09, "R9");
        step(16'h0000,          1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
        step(16'h0002,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h11, "R3");
        step(16'h8002,          1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h1F, "R4");
        step(16'h8002,          1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R9");
        step(16'h8002,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R7");
        step(16'h0000,          1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule